// File: doc/BRIEF.md
# Belt Operand Store with Call Frames

This block keeps a short queue of operand values, the belt. Each new result enters at the front and pushes the older entries back one place, so the oldest entry falls off the far end. An operand is read by naming how far back from the front it sits. Every slot carries its own valid bit. A slot whose bit is clear holds the not-a-value marker. Reading such a slot returns the marker and raises no error.

Subroutine calls and returns keep caller and callee contents apart. On a call, the current belt is pushed onto a small frame stack. The callee then starts with a fresh belt that holds only the argument positions the caller chose, at the front and in the order listed. Every other slot starts as not-a-value. On a return, the callee belt is thrown away and the saved caller belt comes back. The named callee results go at its front, and the saved entries move back by the number of results. Each operation takes effect at a single clock edge. A call with the frame stack full, or a return with it empty, raises a flag and changes nothing.

Top module: `belt_store`

## Requirements
- R1: After a synchronous reset, all 8 belt positions read as not-a-value (rd_valid=0, rd_data=0) and the frame stack is empty.
- R2: op=01 (push) places {valid, push_data} at position 0 and moves the entry at position i to position i+1. The entry at position 7 is lost.
- R3: A read of a not-a-value slot returns rd_valid=0 and rd_data=0. Neither overflow nor underflow is raised.
- R4: op=10 (call) with the stack not full builds a callee belt. For k<cnt, position k holds the caller entry at position idx_vec[3k+2:3k]. Every position k>=cnt is not-a-value.
- R5: Call arguments may name caller positions in any order, and may name the same position more than once. Each one is copied on its own.
- R6: op=11 (return) with the stack not empty builds the result belt from the callee entries at idx_vec[3k+2:3k], placed at positions k<cnt. Position k>=cnt holds the saved caller entry k-cnt. The last cnt saved entries are lost.
- R7: A return with cnt=0 restores the saved caller belt exactly, and all callee contents are discarded.
- R8: Frames nest up to 4 deep and are restored in last-in, first-out order.
- R9: A call while 4 frames are saved drives overflow high in that cycle and leaves the belt and the stack unchanged.
- R10: A return while no frame is saved drives underflow high in that cycle and leaves the belt unchanged.
- R11: The read port shows the belt before an operation during that operation's cycle. The whole update is visible from the cycle after the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op | input | 2 | 00 idle, 01 push, 10 call, 11 return |
| push_data | input | 16 | Value entered by a push |
| cnt | input | 4 | Number of argument or result positions, 0 to 8 |
| idx_vec | input | 24 | Packed positions, entry k at bits 3k+2:3k |
| rd_idx | input | 3 | Read position, counted from the front |
| rd_valid | output | 1 | Valid bit of the slot being read, 0 for not-a-value |
| rd_data | output | 16 | Value of the slot being read, 0 for not-a-value |
| overflow | output | 1 | High while a call is requested with the frame stack full |
| underflow | output | 1 | High while a return is requested with the frame stack empty |

## Verification
The assertions assume that cnt never exceeds 8. They also assume that op stays idle while reset is held, and that reset is held for at least one clock edge before anything else happens. They take nothing else for granted: any index pattern, any repeated position and any call depth is legal input. The stimulus keeps cnt between 0 and 8 and holds op idle through reset. It then drives a wide range of index patterns, including every single-argument position, rotated orderings, repeated positions and every result count from 0 to 8. It also takes the stack to full and back down to empty.

// File: rtl/belt_pkg.sv
package belt_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_PUSH = 2'b01,
    OP_CALL = 2'b10,
    OP_RET  = 2'b11
  } belt_op_e;

  // True when output position k is filled from the source list
  function automatic logic from_list(input int k, input int n);
    return k < n;
  endfunction

  // Source position in the tail belt for output position k
  function automatic int tail_slot(input int k, input int n);
    return k - n;
  endfunction
endpackage

// File: rtl/belt_gather.sv
module belt_gather #(
  parameter int BL = 8,
  parameter int SW = 17,
  parameter int IW = 3,
  parameter int CW = 4
) (
  input  logic [BL-1:0][SW-1:0] src,
  input  logic [BL-1:0][SW-1:0] tail,
  input  logic [CW-1:0]         cnt,
  input  logic [BL*IW-1:0]      idx_vec,
  output logic [BL-1:0][SW-1:0] dout
);
  import belt_pkg::*;

  for (genvar k = 0; k < BL; k++) begin : g_pos
    logic [IW-1:0] sel;
    assign sel = idx_vec[k*IW +: IW];
    always_comb begin
      dout[k] = '0;
      if (from_list(k, int'(cnt))) begin
        dout[k] = src[sel];
      end else begin
        for (int j = 0; j < BL; j++) begin
          if (j == tail_slot(k, int'(cnt))) dout[k] = tail[j];
        end
      end
    end
  end
endmodule

// File: rtl/belt_frame_stack.sv
module belt_frame_stack #(
  parameter int FD = 4,
  parameter int BL = 8,
  parameter int SW = 17
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  push,
  input  logic                  pop,
  input  logic [BL-1:0][SW-1:0] din,
  output logic [BL-1:0][SW-1:0] top,
  output logic                  full,
  output logic                  empty
);
  localparam int SPW = $clog2(FD + 1);
  localparam int AW  = (FD > 1) ? $clog2(FD) : 1;

  logic [FD-1:0][BL-1:0][SW-1:0] mem;
  logic [SPW-1:0] sp;
  logic [SPW-1:0] top_i;

  assign full  = (sp == SPW'(FD));
  assign empty = (sp == '0);
  assign top_i = sp - SPW'(1);
  assign top   = empty ? '0 : mem[top_i[AW-1:0]];

  always_ff @(posedge clk) begin
    if (rst) begin
      sp <= '0;
    end else if (push && !full) begin
      mem[sp[AW-1:0]] <= din;
      sp <= sp + SPW'(1);
    end else if (pop && !empty) begin
      sp <= sp - SPW'(1);
    end
  end

  a_r8_push_depth: assert property (@(posedge clk) disable iff (rst)
    (push && !full) |=> (sp == $past(sp) + SPW'(1)));
  a_r8_pop_depth: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && !empty) |=> (sp == $past(sp) - SPW'(1)));
  a_r9_full_hold: assert property (@(posedge clk) disable iff (rst)
    (push && full) |=> $stable(sp));
  a_r8_saved_frame: assert property (@(posedge clk) disable iff (rst)
    (push && !full) |=> (top == $past(din)));
endmodule

// File: rtl/belt_store.sv
module belt_store #(
  parameter int BL = 8,
  parameter int DW = 16,
  parameter int FD = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [1:0]               op,
  input  logic [DW-1:0]            push_data,
  input  logic [$clog2(BL+1)-1:0]  cnt,
  input  logic [BL*$clog2(BL)-1:0] idx_vec,
  input  logic [$clog2(BL)-1:0]    rd_idx,
  output logic                     rd_valid,
  output logic [DW-1:0]            rd_data,
  output logic                     overflow,
  output logic                     underflow
);
  import belt_pkg::*;

  localparam int SW = DW + 1;
  localparam int IW = $clog2(BL);
  localparam int CW = $clog2(BL + 1);

  belt_op_e opc;
  logic [BL-1:0][SW-1:0] belt_q, belt_d, gathered, tail;
  logic [BL-1:0][SW-1:0] stk_top;
  logic [BL-1:0] valid_bits;
  logic stk_full, stk_empty;
  logic ev_push, ev_call, ev_ret, ev_ovf, ev_unf;
  logic [SW-1:0] rd_slot;

  assign opc     = belt_op_e'(op);
  assign ev_push = (opc == OP_PUSH);
  assign ev_call = (opc == OP_CALL) && !stk_full;
  assign ev_ret  = (opc == OP_RET) && !stk_empty;
  assign ev_ovf  = (opc == OP_CALL) && stk_full;
  assign ev_unf  = (opc == OP_RET) && stk_empty;

  assign overflow  = ev_ovf;
  assign underflow = ev_unf;

  for (genvar i = 0; i < BL; i++) begin : g_vld
    assign valid_bits[i] = belt_q[i][SW-1];
  end

  assign tail = ev_ret ? stk_top : '0;

  belt_gather #(.BL(BL), .SW(SW), .IW(IW), .CW(CW)) u_gather (
    .src(belt_q), .tail(tail), .cnt(cnt), .idx_vec(idx_vec), .dout(gathered)
  );

  belt_frame_stack #(.FD(FD), .BL(BL), .SW(SW)) u_stack (
    .clk(clk), .rst(rst), .push(ev_call), .pop(ev_ret), .din(belt_q),
    .top(stk_top), .full(stk_full), .empty(stk_empty)
  );

  always_comb begin
    belt_d = belt_q;
    if (ev_push) begin
      belt_d[0] = {1'b1, push_data};
      for (int i = 1; i < BL; i++) belt_d[i] = belt_q[i-1];
    end else if (ev_call || ev_ret) begin
      belt_d = gathered;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) belt_q <= '0;
    else     belt_q <= belt_d;
  end

  assign rd_slot  = belt_q[rd_idx];
  assign rd_valid = rd_slot[SW-1];
  assign rd_data  = rd_slot[SW-1] ? rd_slot[DW-1:0] : '0;

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (valid_bits == '0));
  a_r2_push_shift: assert property (@(posedge clk) disable iff (rst)
    ev_push |=> (belt_q[1] == $past(belt_q[0])) &&
                (belt_q[0] == {1'b1, $past(push_data)}));
  a_r4_call_no_args: assert property (@(posedge clk) disable iff (rst)
    (ev_call && cnt == '0) |=> (valid_bits == '0));
  a_r9_overflow_hold: assert property (@(posedge clk) disable iff (rst)
    ev_ovf |=> $stable(belt_q));
  a_r10_underflow_hold: assert property (@(posedge clk) disable iff (rst)
    ev_unf |=> $stable(belt_q));
  a_r3_nar_reads_zero: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> (rd_data == '0));
endmodule

// File: tb/belt_store_test.sv
`timescale 1ns/1ps
module belt_store_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0]  op = 2'b00;
  logic [15:0] push_data = '0;
  logic [3:0]  cnt = '0;
  logic [23:0] idx_vec = '0;
  logic [2:0]  rd_idx = '0;
  logic rd_valid, overflow, underflow;
  logic [15:0] rd_data;

  int checks = 0;
  int failures = 0;

  logic [16:0] mb [8];
  logic [16:0] ms [4][8];
  int msp = 0;

  always #4 clk = ~clk;

  belt_store uut (
    .clk(clk), .rst(rst), .op(op), .push_data(push_data), .cnt(cnt),
    .idx_vec(idx_vec), .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_data(rd_data),
    .overflow(overflow), .underflow(underflow)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_belt(input string tag);
    for (int p = 0; p < 8; p++) begin
      rd_idx = p[2:0];
      #0.2;
      if (mb[p][16] == 1'b0) chk("R3 nar slot", {15'd0, rd_valid, rd_data}, {15'd0, mb[p]});
      else chk(tag, {15'd0, rd_valid, rd_data}, {15'd0, mb[p]});
    end
    chk("R3 no flag when idle", {30'd0, overflow, underflow}, 32'd0);
  endtask

  function automatic logic [23:0] pack_idx(input int mul, input int add);
    logic [23:0] v = '0;
    for (int k = 0; k < 8; k++) v[3*k +: 3] = 3'((k * mul + add) % 8);
    return v;
  endfunction

  task automatic apply(input logic [1:0] o, input logic [15:0] d, input int n,
                       input logic [23:0] iv, input string tag);
    logic [16:0] nb [8];
    logic eo, eu;
    @(negedge clk);
    op = o; push_data = d; cnt = n[3:0]; idx_vec = iv; rd_idx = 3'd0;
    #1;
    eo = (o == 2'b10) && (msp == 4);
    eu = (o == 2'b11) && (msp == 0);
    chk("R9 overflow flag", {31'd0, overflow}, {31'd0, eo});
    chk("R10 underflow flag", {31'd0, underflow}, {31'd0, eu});
    chk("R11 old belt during op", {15'd0, rd_valid, rd_data}, {15'd0, mb[0]});
    for (int i = 0; i < 8; i++) nb[i] = mb[i];
    if (o == 2'b01) begin
      nb[0] = {1'b1, d};
      for (int i = 1; i < 8; i++) nb[i] = mb[i-1];
    end else if (o == 2'b10 && !eo) begin
      for (int i = 0; i < 8; i++) ms[msp][i] = mb[i];
      msp++;
      for (int k = 0; k < 8; k++) nb[k] = (k < n) ? mb[iv[3*k +: 3]] : 17'd0;
    end else if (o == 2'b11 && !eu) begin
      msp--;
      for (int k = 0; k < 8; k++) nb[k] = (k < n) ? mb[iv[3*k +: 3]] : ms[msp][k-n];
    end
    @(posedge clk);
    for (int i = 0; i < 8; i++) mb[i] = nb[i];
    @(negedge clk);
    op = 2'b00;
    check_belt(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) mb[i] = 17'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check_belt("R1 reset clears belt");

    apply(2'b11, 16'h0, 0, 24'h0, "R10 return on empty stack");
    apply(2'b11, 16'h0, 2, pack_idx(1, 0), "R1 stack empty after reset");

    for (int i = 0; i < 10; i++)
      apply(2'b01, 16'(16'h1000 + i * 16'h111), 0, 24'h0, "R2 push shift");

    for (int p = 0; p < 8; p++) begin
      apply(2'b10, 16'h0, 1, 24'(p), "R4 single argument call");
      apply(2'b11, 16'h0, 0, 24'h0, "R7 plain return restores");
    end

    for (int n = 0; n <= 8; n++) begin
      apply(2'b10, 16'h0, n, pack_idx(3, n), "R5 rotated argument order");
      apply(2'b01, 16'(16'hA000 + n), 0, 24'h0, "R2 push in callee");
      apply(2'b11, 16'h0, 8 - n, pack_idx(5, 1), "R6 return with results");
    end

    apply(2'b10, 16'h0, 5, pack_idx(0, 2), "R5 repeated argument");
    apply(2'b11, 16'h0, 3, pack_idx(0, 4), "R6 repeated result");

    for (int lv = 0; lv < 4; lv++) begin
      apply(2'b01, 16'(16'hC000 + lv), 0, 24'h0, "R2 push before nest");
      apply(2'b10, 16'h0, 2, pack_idx(1, lv), "R8 nested call");
    end
    apply(2'b01, 16'hD00D, 0, 24'h0, "R2 push at depth 4");
    apply(2'b10, 16'h0, 3, pack_idx(1, 0), "R9 call with full stack");
    for (int lv = 0; lv < 4; lv++)
      apply(2'b11, 16'h0, 1, pack_idx(1, lv), "R8 nested return order");
    apply(2'b11, 16'h0, 1, pack_idx(1, 0), "R10 return past bottom");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule